// File: doc/BRIEF.md
# Windowed Threshold Interrupt Generator

This block watches one of several measurement channels and raises an interrupt when a fresh sample falls outside a programmable window. Software sets a lower and an upper 16-bit limit over a byte-wide register bus. Each limit is split across two byte registers. A separate source register picks which channel is compared. A comparison is made only on a cycle where the new-sample strobe is high.

The window is not symmetric. A sample at or below the lower limit fires. A sample fires at the upper end only when it is strictly greater than the upper limit, so a sample equal to the upper limit does not fire. Once set, the interrupt output stays high until a clear pulse arrives. If a new firing sample and a clear pulse arrive in the same cycle, the firing sample wins.

Top module: `win_irq_top`

## Requirements
- R1: After synchronous reset, all four limit bytes and the source field are 0, `irq` is 0 and `reg_rdata` is 0.
- R2: Lower limit = {byte at 09h, byte at 08h}. Upper limit = {byte at 0Bh, byte at 0Ah}. A write with `reg_wr` high stores `reg_wdata` at the next clock edge. Reading an address returns the stored byte on `reg_rdata` one cycle after the address is presented.
- R3: Bits [1:0] of the byte written at 03h select channel k. Channel k is `ch_data[16k+15:16k]`. Upper bits of that write are dropped, and they read back as 0.
- R4: A strobed sample that is less than or equal to the lower limit sets `irq` at the clock edge that samples the strobe.
- R5: A strobed sample that is strictly greater than the upper limit sets `irq` at that edge. A sample equal to the upper limit does not set it.
- R6: Channel values present while `sample_vld` is low never change `irq`.
- R7: `irq` stays high through later in-window samples until `irq_clr` is high at a clock edge. At that edge `irq` returns to 0.
- R8: When a firing sample and `irq_clr` meet at the same edge, `irq` ends up 1.
- R9: A limit write takes effect on the first strobe at a later edge. A strobe at the same edge as the write still uses the old limit. Writes on consecutive cycles to both bytes of a limit, followed at once by a strobe, compare against the full new value.
- R10: Writes to any address other than 03h and 08h–0Bh change no register, and such addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| ch_data | input | 64 | Four packed 16-bit channel values, channel 0 in the low bits |
| sample_vld | input | 1 | New-sample strobe |
| irq_clr | input | 1 | Interrupt clear pulse |
| irq | output | 1 | Sticky interrupt output |

## Verification
Every result appears exactly one clock edge after its stimulus:
- a register write can be read back, and can steer a compare, from the following cycle;
- read data follows its address by one cycle;
- `irq` reflects a strobe or a clear at the edge that samples it.

The bench changes inputs on the falling edge. It reads outputs at the next falling edge, half a period after the single register stage. Tests of the same-edge cases also check the cycle in which the late result must not yet show: a write beside a strobe, and a clear beside a firing sample.

// File: rtl/wirq_pkg.sv
package wirq_pkg;
  localparam int                 REG_ADDR_W = 8;
  localparam int                 REG_BYTE_W = 8;
  localparam logic [7:0]         SRC_SEL_ADDR = 8'h03;
  localparam logic [7:0]         LIMIT_BASE_ADDR = 8'h08;
endpackage

// File: rtl/wirq_regs.sv
module wirq_regs #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int DATA_W = 16,
  parameter int SEL_W = 2,
  parameter logic [ADDR_W-1:0] SRC_ADDR = 8'h03,
  parameter logic [ADDR_W-1:0] LIM_BASE = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr,
  output logic [BYTE_W-1:0] rdata,
  output logic [DATA_W-1:0] lim_lo,
  output logic [DATA_W-1:0] lim_hi,
  output logic [SEL_W-1:0]  sel
);
  localparam int NB = DATA_W / BYTE_W;
  localparam int NBYTES = 2 * NB;

  logic [BYTE_W-1:0] lim_q [NBYTES];
  logic [SEL_W-1:0]  sel_q;
  logic [BYTE_W-1:0] rd_nxt;
  logic              hit_any;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] BADDR = LIM_BASE + ADDR_W'(i);
    always_ff @(posedge clk) begin
      if (rst) lim_q[i] <= '0;
      else if (wr && addr == BADDR) lim_q[i] <= wdata;
    end
    // R2
    byte_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == BADDR) |=> lim_q[i] == $past(wdata));
  end

  for (genvar i = 0; i < NB; i++) begin : g_pack
    assign lim_lo[i*BYTE_W +: BYTE_W] = lim_q[i];
    assign lim_hi[i*BYTE_W +: BYTE_W] = lim_q[NB+i];
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (wr && addr == SRC_ADDR) sel_q <= wdata[SEL_W-1:0];
  end
  assign sel = sel_q;

  always_comb begin
    rd_nxt  = '0;
    hit_any = 1'b0;
    if (addr == SRC_ADDR) begin
      rd_nxt[SEL_W-1:0] = sel_q;
      hit_any = 1'b1;
    end
    for (int i = 0; i < NBYTES; i++) begin
      if (addr == LIM_BASE + ADDR_W'(i)) begin
        rd_nxt  = lim_q[i];
        hit_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_any |=> rdata == '0);
  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == SRC_ADDR) |=> $stable(sel_q));
endmodule

// File: rtl/wirq_cmp.sv
module wirq_cmp #(
  parameter int DATA_W = 16,
  parameter int N_CH = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_CH*DATA_W-1:0] ch_flat,
  input  logic [SEL_W-1:0]       sel,
  input  logic [DATA_W-1:0]      lim_lo,
  input  logic [DATA_W-1:0]      lim_hi,
  input  logic                   vld,
  output logic                   fire
);
  logic [DATA_W-1:0] ch [N_CH];
  logic [DATA_W-1:0] picked;
  logic              below, above;

  for (genvar k = 0; k < N_CH; k++) begin : g_unpack
    assign ch[k] = ch_flat[k*DATA_W +: DATA_W];
  end

  assign picked = ch[sel];
  assign below  = (picked <= lim_lo);
  assign above  = (picked >  lim_hi);
  assign fire   = vld && (below || above);
endmodule

// File: rtl/wirq_flag.sv
module wirq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> irq_o);
  // R7
  clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !irq_o);
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(irq_o));
endmodule

// File: rtl/win_irq_top.sv
module win_irq_top #(
  parameter int DATA_W = 16,
  parameter int N_CH = 4,
  parameter int ADDR_W = wirq_pkg::REG_ADDR_W,
  parameter int BYTE_W = wirq_pkg::REG_BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [BYTE_W-1:0]      reg_wdata,
  input  logic                   reg_wr,
  output logic [BYTE_W-1:0]      reg_rdata,
  input  logic [N_CH*DATA_W-1:0] ch_data,
  input  logic                   sample_vld,
  input  logic                   irq_clr,
  output logic                   irq
);
  localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [DATA_W-1:0] lim_lo, lim_hi;
  logic [SEL_W-1:0]  sel;
  logic              fire;

  wirq_regs #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .SRC_ADDR(ADDR_W'(wirq_pkg::SRC_SEL_ADDR)),
    .LIM_BASE(ADDR_W'(wirq_pkg::LIMIT_BASE_ADDR))
  ) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .wr(reg_wr),
    .rdata(reg_rdata), .lim_lo(lim_lo), .lim_hi(lim_hi), .sel(sel)
  );

  wirq_cmp #(.DATA_W(DATA_W), .N_CH(N_CH), .SEL_W(SEL_W)) u_cmp (
    .ch_flat(ch_data), .sel(sel), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .vld(sample_vld), .fire(fire)
  );

  wirq_flag u_flag (
    .clk(clk), .rst(rst), .set_i(fire), .clr_i(irq_clr), .irq_o(irq)
  );

  // R6
  strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |=> !$rose(irq));
endmodule

// File: tb/sim_win_irq_top.sv
module sim_win_irq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_rdata;
  logic [63:0] ch_data = '0;
  logic        sample_vld = 1'b0;
  logic        irq_clr = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  win_irq_top u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .ch_data(ch_data),
    .sample_vld(sample_vld), .irq_clr(irq_clr), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All helpers are entered and left at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic strobe(input logic [15:0] v0, v1, v2, v3);
    ch_data = {v3, v2, v1, v0}; sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic set_limits(input logic [15:0] lo, input logic [15:0] hi);
    wr(8'h08, lo[7:0]); wr(8'h09, lo[15:8]);
    wr(8'h0A, hi[7:0]); wr(8'h0B, hi[15:8]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 rdata", {8'd0, reg_rdata}, 16'd0);
    for (int a = 8; a < 12; a++) begin
      rd(8'(a), d);
      chk("R1 limit byte", {8'd0, d}, 16'd0);
    end
    rd(8'h03, d);
    chk("R1 source", {8'd0, d}, 16'd0);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    set_limits(16'h1234, 16'h5678);
    rd(8'h08, d); chk("R2 08h", {8'd0, d}, 16'h34);
    rd(8'h09, d); chk("R2 09h", {8'd0, d}, 16'h12);
    rd(8'h0A, d); chk("R2 0Ah", {8'd0, d}, 16'h78);
    rd(8'h0B, d); chk("R2 0Bh", {8'd0, d}, 16'h56);
  endtask

  task automatic t_select();
    logic [7:0] d;
    set_limits(16'd100, 16'd1000);
    wr(8'h03, 8'hFE);
    rd(8'h03, d); chk("R3 source readback", {8'd0, d}, 16'h02);
    strobe(16'd50, 16'd50, 16'd500, 16'd50);
    chk("R3 ch2 in window", {15'd0, irq}, 16'd0);
    strobe(16'd500, 16'd500, 16'd50, 16'd500);
    chk("R3 ch2 low fires", {15'd0, irq}, 16'd1);
    clear_irq();
    wr(8'h03, 8'h03);
    strobe(16'd5000, 16'd5000, 16'd5000, 16'd500);
    chk("R3 ch3 in window", {15'd0, irq}, 16'd0);
    strobe(16'd500, 16'd500, 16'd500, 16'd5000);
    chk("R3 ch3 high fires", {15'd0, irq}, 16'd1);
    clear_irq();
    wr(8'h03, 8'h00);
  endtask

  task automatic t_low();
    strobe(16'd101, 0, 0, 0);
    chk("R4 just above low", {15'd0, irq}, 16'd0);
    strobe(16'd100, 0, 0, 0);
    chk("R4 equal low fires", {15'd0, irq}, 16'd1);
    clear_irq();
    strobe(16'd0, 0, 0, 0);
    chk("R4 zero fires", {15'd0, irq}, 16'd1);
    clear_irq();
  endtask

  task automatic t_high();
    strobe(16'd1000, 0, 0, 0);
    chk("R5 equal high quiet", {15'd0, irq}, 16'd0);
    strobe(16'd1001, 0, 0, 0);
    chk("R5 above high fires", {15'd0, irq}, 16'd1);
    clear_irq();
    strobe(16'hFFFF, 0, 0, 0);
    chk("R5 max fires", {15'd0, irq}, 16'd1);
    clear_irq();
  endtask

  task automatic t_nostrobe();
    ch_data = {16'd0, 16'd0, 16'd0, 16'd0};
    repeat (3) @(negedge clk);
    ch_data = {4{16'hFFFF}};
    repeat (3) @(negedge clk);
    chk("R6 no strobe", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_sticky();
    strobe(16'd10, 0, 0, 0);
    chk("R7 set", {15'd0, irq}, 16'd1);
    strobe(16'd500, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R7 held", {15'd0, irq}, 16'd1);
    clear_irq();
    chk("R7 cleared", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_setwins();
    irq_clr = 1'b1;
    strobe(16'd10, 0, 0, 0);
    irq_clr = 1'b0;
    chk("R8 set over clear", {15'd0, irq}, 16'd1);
    irq_clr = 1'b1;
    strobe(16'd500, 0, 0, 0);
    irq_clr = 1'b0;
    chk("R7 clear beside quiet sample", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_update();
    // low = 100 now; write 08h=FF beside a strobe of 200
    reg_addr = 8'h08; reg_wdata = 8'hFF; reg_wr = 1'b1;
    ch_data = {48'd0, 16'd200}; sample_vld = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; sample_vld = 1'b0;
    chk("R9 same-edge uses old", {15'd0, irq}, 16'd0);
    strobe(16'd200, 0, 0, 0);
    chk("R9 next strobe uses new", {15'd0, irq}, 16'd1);
    clear_irq();
    // back-to-back upper limit = 0x0100, then immediate strobe of 0x0150
    wr(8'h0A, 8'h00); wr(8'h0B, 8'h01);
    strobe(16'h0150, 0, 0, 0);
    chk("R9 back-to-back words", {15'd0, irq}, 16'd1);
    clear_irq();
    strobe(16'h0100, 0, 0, 0);
    chk("R9 new high equal quiet", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(8'h0C, 8'hAA); wr(8'h07, 8'h33); wr(8'h04, 8'h55); wr(8'h02, 8'h01);
    rd(8'h08, d); chk("R10 08h kept", {8'd0, d}, 16'hFF);
    rd(8'h09, d); chk("R10 09h kept", {8'd0, d}, 16'h00);
    rd(8'h0A, d); chk("R10 0Ah kept", {8'd0, d}, 16'h00);
    rd(8'h0B, d); chk("R10 0Bh kept", {8'd0, d}, 16'h01);
    rd(8'h03, d); chk("R10 source kept", {8'd0, d}, 16'h00);
    rd(8'h0C, d); chk("R10 0Ch reads 0", {8'd0, d}, 16'h00);
    rd(8'h04, d); chk("R10 04h reads 0", {8'd0, d}, 16'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_select();
    t_low();
    t_high();
    t_nostrobe();
    t_sticky();
    t_setwins();
    t_update();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule